// File: doc/BRIEF.md
# Bus Reset Contract Monitor

This block is a synthesizable watcher placed beside one peripheral on an APB bus. It observes the active-low bus reset, the handshake signals, a read-data drive indication from the peripheral, and a tap of the peripheral's internal registers. It reports every breach of the bring-up contract: the peripheral stays quiet while the bus is held in reset, the reset release arrives in step with the clock, every tapped register shows its specified starting value on the first live cycle, and the first transfer after release opens with a setup cycle rather than an access cycle.

Each rule has its own sticky flag. A flag also latches a cycle stamp taken from a free-running edge counter. A single code reports which rule fired first. The monitor's own state is cleared only by a synchronous active-high clear input, so findings survive later bus resets and can be inspected afterwards.

The monitor drives nothing on the bus. It can sit on a live chip as a permanent checker, or in a test bench next to a peripheral under test.

Top module: `rstchk_monitor`

## Requirements
- R1: A rising clock edge that samples the bus reset low together with `rd_drive` high sets flag bit 0 (quiet-output breach). `rd_drive` high while the reset is high sets no flag.
- R2: A rising edge that samples the reset low with `psel`, `penable`, `pready` and `pwrite` all high sets flag bit 1 (write committed in reset). The same pattern with `pwrite` low sets nothing.
- R3: Flag bit 2 (register disturbed in reset) is set by a rising edge that meets three conditions: the reset is low at this edge and at the previous edge, `psel` or `penable` was high at the previous edge, and `tap_bus` differs from its value at the previous edge. A tap change in reset with no select or enable seen sets nothing.
- R4: `bus_rst_n` is also sampled on every falling edge. A release (0 at one rising edge, 1 at the following falling edge) sets flag bit 3 (release out of step) at the next rising edge. A release that happens in the low phase, after the falling edge and before the rising edge, sets nothing.
- R5: On the first rising edge that samples the reset high after one that sampled it low, a mismatch of any tapped register against its default sets flag bit 4. With the default parameters the defaults are register 1 = 0xA5 (tap bits 15:8) and register 0 = 0x3C (tap bits 7:0).
- R6: After any edge that samples the reset low, the first edge with the reset high and `psel` high must have `penable` low. `penable` high there sets flag bit 5. A setup cycle followed by an access cycle sets nothing.
- R7: Flags are sticky. They hold through any later activity of `bus_rst_n`, and only `chk_clr` sampled high at a rising edge returns all flags, stamps and the code to 0.
- R8: When a flag is first set, its `err_stamps` slice (bits 16*i+15:16*i for flag i) latches the number of rising edges with `chk_clr` low since the last clearing edge, not counting the firing edge itself. The stamp then holds until a clear.
- R9: `err_code` is 0 while no flag is set. It becomes i+1 for the first flag i that fires, taking the lowest index if several fire on the same edge, and holds until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Observed bus reset, low = in reset |
| chk_clr | input | 1 | Synchronous active-high clear of the monitor's own state |
| psel | input | 1 | Observed peripheral select |
| penable | input | 1 | Observed access-phase enable |
| pwrite | input | 1 | Observed write direction |
| pready | input | 1 | Observed peripheral ready |
| rd_drive | input | 1 | Peripheral is driving the shared read-data return path |
| tap_bus | input | NREG*REG_W | Concatenated tapped peripheral registers, register 0 lowest |
| err_flags | output | 6 | Sticky rule flags, bit i per rule |
| err_code | output | 4 | Code of the first rule that fired, 0 = none |
| err_stamps | output | 6*CNT_W | Per-flag cycle stamps, flag i in slice i |

## Verification
The hardest case to reach from the ports is the release-timing rule. Both the legal and the illegal release differ only in where the reset edge falls within one clock period. The bench therefore moves `bus_rst_n` a short delay after a rising edge for the faulty case, and a short delay after a falling edge for the clean case. The register-disturbance rule needs a select in one reset cycle and a tap change in the next, so the bench scripts that pair of cycles explicitly, and first shows that a tap change with no select stays silent.

// File: rtl/rstchk_pkg.sv
package rstchk_pkg;

    localparam int NUM_RULES = 6;
    localparam int CODE_W    = 4;

    typedef enum logic [2:0] {
        RULE_DRIVE  = 3'd0,
        RULE_COMMIT = 3'd1,
        RULE_ACT    = 3'd2,
        RULE_REL    = 3'd3,
        RULE_DEF    = 3'd4,
        RULE_SEQ    = 3'd5
    } rule_e;

    typedef logic [NUM_RULES-1:0] rule_vec_t;

    // Bus signals as seen at one rising edge
    typedef struct packed {
        logic sel;
        logic en;
        logic wr;
        logic rdy;
        logic drv;
    } bus_snap_t;

    // Recorded history used by the rules
    typedef struct packed {
        logic vld;       // at least one edge since the last clear
        logic rst_n_q;   // reset level at the previous rising edge
        logic sel_q;
        logic en_q;
        logic armed;     // waiting for the first selected cycle after reset
        logic neg_rst_n; // reset level at the latest falling edge
    } hist_t;

    // Lowest set rule index, plus one; 0 when nothing set
    function automatic logic [CODE_W-1:0] first_code(rule_vec_t v);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (v[i]) c = CODE_W'(i + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rstchk_history.sv
module rstchk_history
    import rstchk_pkg::*;
#(
    parameter int NREG  = 2,
    parameter int REG_W = 8,
    localparam int TAP_W = NREG * REG_W
) (
    input  logic             clk,
    input  logic             chk_clr,
    input  logic             bus_rst_n,
    input  logic             sel,
    input  logic             en,
    input  logic [TAP_W-1:0] taps,
    output hist_t            hist,
    output logic [TAP_W-1:0] taps_q
);

    logic vld_r, rst_q_r, sel_q_r, en_q_r, armed_r, neg_r;

    // Rising-edge history
    always_ff @(posedge clk) begin
        if (chk_clr) begin
            vld_r   <= 1'b0;
            rst_q_r <= 1'b0;
            sel_q_r <= 1'b0;
            en_q_r  <= 1'b0;
            armed_r <= 1'b0;
            taps_q  <= '0;
        end else begin
            vld_r   <= 1'b1;
            rst_q_r <= bus_rst_n;
            sel_q_r <= sel;
            en_q_r  <= en;
            taps_q  <= taps;
            if (!bus_rst_n)
                armed_r <= 1'b1;
            else if (sel)
                armed_r <= 1'b0;
        end
    end

    // Falling-edge sample of the reset; only read once vld_r is set,
    // by which time a falling edge has always refreshed it
    always_ff @(negedge clk) begin
        neg_r <= bus_rst_n;
    end

    always_comb begin
        hist.vld       = vld_r;
        hist.rst_n_q   = rst_q_r;
        hist.sel_q     = sel_q_r;
        hist.en_q      = en_q_r;
        hist.armed     = armed_r;
        hist.neg_rst_n = neg_r;
    end

    // R6: leaving a reset edge the first-transfer watch is armed
    assert_arm_after_reset_R6: assert property (@(posedge clk) disable iff (chk_clr)
        !bus_rst_n |=> armed_r);

endmodule

// File: rtl/rstchk_rules.sv
module rstchk_rules
    import rstchk_pkg::*;
#(
    parameter int NREG  = 2,
    parameter int REG_W = 8,
    localparam int TAP_W = NREG * REG_W,
    parameter logic [TAP_W-1:0] TAP_DEFAULTS = '0
) (
    input  logic             bus_rst_n,
    input  bus_snap_t        snap,
    input  hist_t            hist,
    input  logic [TAP_W-1:0] taps,
    input  logic [TAP_W-1:0] taps_q,
    output rule_vec_t        viol
);

    logic [NREG-1:0] chg;
    logic [NREG-1:0] mis;

    for (genvar g = 0; g < NREG; g++) begin : g_tap
        assign chg[g] = taps[g*REG_W +: REG_W] != taps_q[g*REG_W +: REG_W];
        assign mis[g] = taps[g*REG_W +: REG_W] != TAP_DEFAULTS[g*REG_W +: REG_W];
    end

    logic in_rst, released_now;

    always_comb begin
        in_rst       = !bus_rst_n;
        released_now = hist.vld && !hist.rst_n_q && bus_rst_n;
        viol         = '0;

        viol[RULE_DRIVE]  = in_rst && snap.drv;
        viol[RULE_COMMIT] = in_rst && snap.sel && snap.en && snap.rdy && snap.wr;
        viol[RULE_ACT]    = hist.vld && in_rst && !hist.rst_n_q
                            && (hist.sel_q || hist.en_q) && (|chg);
        viol[RULE_REL]    = hist.vld && !hist.rst_n_q && hist.neg_rst_n;
        viol[RULE_DEF]    = released_now && (|mis);
        viol[RULE_SEQ]    = bus_rst_n && hist.armed && snap.sel && snap.en;
    end

endmodule

// File: rtl/rstchk_log.sv
module rstchk_log
    import rstchk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          chk_clr,
    input  rule_vec_t                     viol,
    output logic [NUM_RULES-1:0]          flags,
    output logic [CODE_W-1:0]             code,
    output logic [NUM_RULES*CNT_W-1:0]    stamps
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] stamp_r [NUM_RULES];
    logic [NUM_RULES-1:0] flag_r;

    // Edge counter, saturating
    always_ff @(posedge clk) begin
        if (chk_clr)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    for (genvar gi = 0; gi < NUM_RULES; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (chk_clr) begin
                flag_r[gi]  <= 1'b0;
                stamp_r[gi] <= '0;
            end else if (viol[gi] && !flag_r[gi]) begin
                flag_r[gi]  <= 1'b1;
                stamp_r[gi] <= cnt;
            end
        end
        assign stamps[gi*CNT_W +: CNT_W] = stamp_r[gi];

        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (chk_clr)
            flag_r[gi] |=> flag_r[gi]);

        assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (chk_clr)
            flag_r[gi] |=> $stable(stamp_r[gi]));
    end

    assign flags = flag_r;

    always_ff @(posedge clk) begin
        if (chk_clr)
            code <= '0;
        else if (code == '0 && (|viol))
            code <= first_code(viol);
    end

    assert_code_hold_R9: assert property (@(posedge clk) disable iff (chk_clr)
        (code != '0) |=> $stable(code));

    assert_code_none_R9: assert property (@(posedge clk) disable iff (chk_clr)
        (code == '0) |-> (flag_r == '0));

endmodule

// File: rtl/rstchk_monitor.sv
module rstchk_monitor
    import rstchk_pkg::*;
#(
    parameter int NREG  = 2,
    parameter int REG_W = 8,
    parameter int CNT_W = 16,
    parameter logic [NREG*REG_W-1:0] TAP_DEFAULTS = 16'hA53C
) (
    input  logic                       pclk,
    input  logic                       bus_rst_n,
    input  logic                       chk_clr,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic                       pready,
    input  logic                       rd_drive,
    input  logic [NREG*REG_W-1:0]      tap_bus,
    output logic [NUM_RULES-1:0]       err_flags,
    output logic [CODE_W-1:0]          err_code,
    output logic [NUM_RULES*CNT_W-1:0] err_stamps
);

    localparam int TAP_W = NREG * REG_W;

    bus_snap_t        snap;
    hist_t            hist;
    logic [TAP_W-1:0] taps_q;
    rule_vec_t        viol;

    always_comb begin
        snap.sel = psel;
        snap.en  = penable;
        snap.wr  = pwrite;
        snap.rdy = pready;
        snap.drv = rd_drive;
    end

    rstchk_history #(.NREG(NREG), .REG_W(REG_W)) u_hist (
        .clk       (pclk),
        .chk_clr   (chk_clr),
        .bus_rst_n (bus_rst_n),
        .sel       (psel),
        .en        (penable),
        .taps      (tap_bus),
        .hist      (hist),
        .taps_q    (taps_q)
    );

    rstchk_rules #(.NREG(NREG), .REG_W(REG_W), .TAP_DEFAULTS(TAP_DEFAULTS)) u_rules (
        .bus_rst_n (bus_rst_n),
        .snap      (snap),
        .hist      (hist),
        .taps      (tap_bus),
        .taps_q    (taps_q),
        .viol      (viol)
    );

    rstchk_log #(.CNT_W(CNT_W)) u_log (
        .clk     (pclk),
        .chk_clr (chk_clr),
        .viol    (viol),
        .flags   (err_flags),
        .code    (err_code),
        .stamps  (err_stamps)
    );

    // R1: driving read data in reset is recorded on the next edge
    assert_quiet_drive_R1: assert property (@(posedge pclk) disable iff (chk_clr)
        (!bus_rst_n && rd_drive) |=> err_flags[RULE_DRIVE]);

    // R2: a full write handshake in reset is recorded
    assert_no_commit_R2: assert property (@(posedge pclk) disable iff (chk_clr)
        (!bus_rst_n && psel && penable && pready && pwrite) |=> err_flags[RULE_COMMIT]);

    // R6: access without setup after reset is recorded
    assert_setup_first_R6: assert property (@(posedge pclk) disable iff (chk_clr)
        (bus_rst_n && hist.armed && psel && penable) |=> err_flags[RULE_SEQ]);

endmodule

// File: tb/tb_rstchk_monitor.sv
`timescale 1ns/1ps
module tb_rstchk_monitor;

    localparam int CNT_W = 16;
    localparam logic [15:0] DEF = 16'hA53C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b1;
    logic        sel = 0, en = 0, wr = 0, rdy = 0, drv = 0;
    logic [15:0] taps = DEF;
    logic [5:0]  flags;
    logic [3:0]  code;
    logic [6*CNT_W-1:0] stamps;

    int checks = 0;
    int fails  = 0;
    int n      = 0;

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) n <= clr ? 0 : n + 1;

    rstchk_monitor dut (
        .pclk(clk), .bus_rst_n(rst_n), .chk_clr(clr),
        .psel(sel), .penable(en), .pwrite(wr), .pready(rdy),
        .rd_drive(drv), .tap_bus(taps),
        .err_flags(flags), .err_code(code), .err_stamps(stamps)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stamp_of(int i);
        return 32'(stamps[i*CNT_W +: CNT_W]);
    endfunction

    task automatic after_edge();
        @(posedge clk); #3;
    endtask

    // Bus idle, reset held, monitor cleared, one history edge taken
    task automatic fresh_start();
        @(negedge clk);
        sel = 0; en = 0; wr = 0; rdy = 0; drv = 0; taps = DEF;
        #2 rst_n = 0;
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        @(negedge clk);
    endtask

    task automatic release_clean();
        @(negedge clk); #2 rst_n = 1;
    endtask

    task automatic t_reset_state();
        fresh_start();
        check("R7 reset flags", 32'(flags), 0);
        check("R9 reset code", 32'(code), 0);
    endtask

    task automatic t_drive();
        int exp;
        fresh_start();
        release_clean();
        @(negedge clk); drv = 1;
        after_edge();
        check("R1 drive out of reset ignored", 32'(flags[0]), 0);
        @(negedge clk); #2 rst_n = 0; exp = n;
        after_edge();
        check("R1 drive in reset flagged", 32'(flags[0]), 1);
        check("R9 code drive", 32'(code), 1);
        check("R8 stamp drive", stamp_of(0), 32'(exp));
        @(negedge clk); drv = 0;
    endtask

    task automatic t_commit();
        fresh_start();
        @(negedge clk); sel = 1; en = 1; rdy = 1; wr = 0;
        after_edge();
        check("R2 read handshake ignored", 32'(flags[1]), 0);
        @(negedge clk); wr = 1;
        after_edge();
        check("R2 write commit flagged", 32'(flags[1]), 1);
        check("R9 code commit", 32'(code), 2);
        @(negedge clk); sel = 0; en = 0; rdy = 0; wr = 0;
    endtask

    task automatic t_disturb();
        int exp;
        fresh_start();
        @(negedge clk); taps = 16'h1111;
        after_edge();
        @(negedge clk); taps = DEF;
        after_edge();
        check("R3 tap change without select ignored", 32'(flags[2]), 0);
        @(negedge clk); sel = 1;
        @(negedge clk); sel = 0; taps = 16'h0042; exp = n;
        after_edge();
        check("R3 tap change after select flagged", 32'(flags[2]), 1);
        check("R8 stamp disturb", stamp_of(2), 32'(exp));
        check("R9 code disturb", 32'(code), 3);
        @(negedge clk); taps = DEF;
    endtask

    task automatic t_release();
        fresh_start();
        release_clean();
        after_edge(); after_edge();
        check("R4 clean release not flagged", 32'(flags[3]), 0);
        check("R5 defaults match not flagged", 32'(flags[4]), 0);
        fresh_start();
        @(posedge clk); #2 rst_n = 1;
        after_edge();
        check("R4 high-phase release flagged", 32'(flags[3]), 1);
        check("R9 code release", 32'(code), 4);
    endtask

    task automatic t_defaults();
        fresh_start();
        @(negedge clk); taps = 16'hA53D;
        #2 rst_n = 1;
        after_edge();
        check("R5 default mismatch flagged", 32'(flags[4]), 1);
        check("R9 code default", 32'(code), 5);
        check("R4 no release flag here", 32'(flags[3]), 0);
        @(negedge clk); taps = DEF;
    endtask

    task automatic t_sequence();
        fresh_start();
        release_clean();
        @(negedge clk); sel = 1;
        @(negedge clk); en = 1;
        after_edge();
        check("R6 setup then access clean", 32'(flags[5]), 0);
        @(negedge clk); sel = 0; en = 0;
        fresh_start();
        release_clean();
        @(negedge clk); sel = 1; en = 1;
        after_edge();
        check("R6 access without setup flagged", 32'(flags[5]), 1);
        check("R9 code sequence", 32'(code), 6);
        @(negedge clk); sel = 0; en = 0;
    endtask

    task automatic t_sticky();
        logic [31:0] st;
        fresh_start();
        @(negedge clk); drv = 1;
        after_edge();
        st = stamp_of(0);
        @(negedge clk); drv = 0;
        release_clean();
        after_edge(); after_edge();
        @(negedge clk); #2 rst_n = 0;
        after_edge();
        check("R7 flag survives reset cycling", 32'(flags[0]), 1);
        check("R8 stamp held", stamp_of(0), st);
        @(negedge clk); clr = 1;
        after_edge();
        check("R7 clear drops flags", 32'(flags), 0);
        check("R9 clear drops code", 32'(code), 0);
        @(negedge clk); clr = 0;
    endtask

    task automatic t_first_code();
        fresh_start();
        @(negedge clk); drv = 1; sel = 1; en = 1; rdy = 1; wr = 1;
        after_edge();
        check("R9 simultaneous flags", 32'(flags[1:0]), 3);
        check("R9 lowest code wins", 32'(code), 1);
        @(negedge clk); drv = 0; sel = 0; en = 0; rdy = 0; wr = 0;
        taps = 16'h0000; #2 rst_n = 1;
        after_edge();
        check("R5 later default flag", 32'(flags[4]), 1);
        check("R9 code kept", 32'(code), 1);
        @(negedge clk); taps = DEF;
    endtask

    initial begin
        #(20ns * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_drive();
        t_commit();
        t_disturb();
        t_release();
        t_defaults();
        t_sequence();
        t_sticky();
        t_first_code();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule